// File: doc/BRIEF.md
# Mailbox Command Transaction Engine

This engine runs one complete request/response exchange with a co-processor on behalf of the host. A one-cycle start pulse selects one of three built-in commands. The engine copies that command's five-word frame into a shared message RAM and rings the doorbell to the co-processor. It then reads the to-host mailbox at a programmable interval until the mailbox returns a nonzero response code or the poll budget runs out. After a valid response it reads the five response words back. In every case it finishes by clearing the to-host mailbox.

At the end the engine reports one 32-bit status word. It also decodes argument 0 of the response into a pointer: the pointer is either relative to message RAM, relative to data memory, or flagged as fatal. All bus traffic goes through a single-outstanding register read/write master port. Each transfer is held until the target acknowledges it.

Top module: `mbx_xact_engine`

## Requirements
- R1: On an accepted start with a valid index (0 info, 1 refresh, 2 vendor), the engine writes the five frame words {header, command, arg count, arg 0, checksum} as the first bus transfers, in that order, to addresses 0x100, 0x104, 0x108, 0x10C and 0x110. The frames are {1,1,1,1,4} for info, {1,2,1,1,5} for refresh and {1,2,1,2,6} for vendor. A request holds its address and direction until it is acknowledged.
- R2: Directly after the fifth frame word, the engine writes the value 1 to the doorbell address 0x10.
- R3: After the doorbell, and after every poll that returns zero, `bus_req` stays low for exactly `poll_gap`+1 cycles before the next read of the to-host mailbox at 0x14.
- R4: When MAX_POLLS consecutive polls all return zero, the engine reads no response words and reports status 0x8000_0010. A nonzero value on the last permitted poll still counts as a response.
- R5: The last bus transfer of every issued transaction writes 0 to 0x14. `done` pulses for one cycle in the cycle after that transfer is acknowledged.
- R6: After a nonzero poll, the engine reads five words from 0x100 to 0x110 in ascending order. If word 4 equals the 32-bit wrapping sum of words 0 to 3, the status is the polled response code unchanged (1 means success; error codes pass through as is).
- R7: When the checksum of the response does not match, the status is 0x8000_0004, whatever the response code was.
- R8: Bits [31:28] of response word 3 give the pointer type and bits [27:0] give the offset. For type 1, `ptr_msg` is 1 and `ptr_addr` is offset+0x100. For type 0, both `ptr_msg` and `ptr_fatal` are 0 and `ptr_addr` is the offset. For any other type, `ptr_fatal` is 1.
- R9: A start with index 3 issues no bus transfer. `done` pulses in the next cycle with status 0x8000_0002.
- R10: After reset, `busy`, `done` and `bus_req` are low and the status is 0. `busy` stays high from the cycle after an accepted start through the `done` cycle. A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; sampled only while idle |
| cmd_idx | input | CMD_W | Command selector (0 info, 1 refresh, 2 vendor) |
| poll_gap | input | GAP_W | Idle cycles minus one between mailbox polls |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Result code of the last transaction |
| ptr_msg | output | 1 | Result pointer lies in message RAM |
| ptr_fatal | output | 1 | Result pointer type is not recognised |
| ptr_addr | output | 29 | Decoded result pointer |
| bus_req | output | 1 | Bus transfer request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Byte address of the transfer |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
Two functions can fall in the same cycle. The first pair is the end of the poll budget and the arrival of a response: the responder returns zero on every poll except the last permitted one, where it returns a nonzero code. The engine must then read the response and report that code, not a timeout. The second pair is completion and a new request: a start is driven in the very cycle that `done` pulses. The bench judges it ignored when no further bus transfer appears and `busy` stays low in the following cycles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int FRAME_WORDS = 5;
   localparam int MSG_BASE    = 'h100;
   localparam int DBELL_ADDR  = 'h10;
   localparam int HOSTMB_ADDR = 'h14;
   localparam int OFF_W       = 28;

   localparam logic [31:0] ST_TIMEOUT = 32'h8000_0010;
   localparam logic [31:0] ST_BADSUM  = 32'h8000_0004;
   localparam logic [31:0] ST_BADCMD  = 32'h8000_0002;

   typedef enum logic [2:0] {
      S_IDLE, S_WRITE, S_RING, S_WAIT, S_POLL, S_READ, S_CLEAR, S_DONE
   } xact_state_t;

   // Word fld (0..4) of the frame for command sel.
   function automatic logic [31:0] cmd_word(input int sel, input int fld);
      logic [31:0] w;
      case (fld)
         0:       w = 32'd1;
         1:       w = (sel == 0) ? 32'd1 : 32'd2;
         2:       w = 32'd1;
         3:       w = (sel == 2) ? 32'd2 : 32'd1;
         default: w = 32'(4 + sel);
      endcase
      return w;
   endfunction

endpackage

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
   parameter int GAP_W     = 16,
   parameter int MAX_POLLS = 200000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [GAP_W-1:0] gap_i,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic             miss_i,
   output logic             gap_done_o,
   output logic             last_o
);
   localparam int PC_W = $clog2(MAX_POLLS + 1);

   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               gap_q <= '0;
      else if (load_i)          gap_q <= gap_i;
      else if (run_i && gap_q != '0) gap_q <= gap_q - 1'b1;
   end

   assign gap_done_o = run_i && (gap_q == '0);

   generate
      if (MAX_POLLS == 1) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_count
         logic [PC_W-1:0] polls_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      polls_q <= '0;
            else if (clr_i)  polls_q <= '0;
            else if (miss_i) polls_q <= polls_q + 1'b1;
         end
         assign last_o = (polls_q == PC_W'(MAX_POLLS - 1));

         p_poll_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            miss_i |-> (polls_q < PC_W'(MAX_POLLS)));
      end
   endgenerate

   p_no_wait_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !gap_done_o || (gap_i == '0));

endmodule

// File: rtl/mbx_resp_check.sv
module mbx_resp_check
   import mbx_pkg::*;
#(
   parameter int BASE = MSG_BASE
) (
   input  logic [FRAME_WORDS-1:0][31:0] words_i,
   output logic                         sum_ok_o,
   output logic                         ptr_msg_o,
   output logic                         ptr_fatal_o,
   output logic [OFF_W:0]               ptr_addr_o
);
   logic [31:0]      sum;
   logic [3:0]       kind;
   logic [OFF_W-1:0] offs;

   always_comb begin
      sum = '0;
      for (int i = 0; i < FRAME_WORDS - 1; i++) sum = sum + words_i[i];
   end

   assign sum_ok_o    = (sum == words_i[FRAME_WORDS-1]);
   assign kind        = words_i[3][31:28];
   assign offs        = words_i[3][OFF_W-1:0];
   assign ptr_msg_o   = (kind == 4'd1);
   assign ptr_fatal_o = (kind > 4'd1);
   assign ptr_addr_o  = ptr_msg_o ? ({1'b0, offs} + (OFF_W+1)'(BASE))
                                  : {1'b0, offs};
endmodule

// File: rtl/mbx_xact_engine.sv
module mbx_xact_engine
   import mbx_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int CMD_W     = 2,
   parameter int N_CMDS    = 3,
   parameter int GAP_W     = 16,
   parameter int MAX_POLLS = 200000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CMD_W-1:0]  cmd_idx,
   input  logic [GAP_W-1:0]  poll_gap,
   output logic              busy,
   output logic              done,
   output logic [31:0]       status,
   output logic              ptr_msg,
   output logic              ptr_fatal,
   output logic [OFF_W:0]    ptr_addr,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [31:0]       bus_rdata
);
   localparam int IDX_W = $clog2(FRAME_WORDS);

   generate
      if (ADDR_W < 9)               begin : g_bad_addr $error("ADDR_W too small for message RAM"); end
      if (N_CMDS > (1 << CMD_W))    begin : g_bad_cmd  $error("CMD_W cannot index all commands"); end
      if (MAX_POLLS < 1)            begin : g_bad_poll $error("MAX_POLLS must be positive"); end
   endgenerate

   xact_state_t                  st_q;
   logic [IDX_W-1:0]             idx_q;
   logic [CMD_W-1:0]             cmd_q;
   logic [FRAME_WORDS-1:0][31:0] rsp_q;
   logic [31:0]                  code_q, status_q;
   logic                         tmo_q;
   logic                         xfer, miss, gap_done, last_poll, sum_ok;

   assign xfer = bus_req && bus_ack;
   assign miss = (st_q == S_POLL) && xfer && (bus_rdata == '0);

   mbx_poll_timer #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (((st_q == S_RING) && xfer) || (miss && !last_poll)),
      .gap_i     (poll_gap),
      .run_i     (st_q == S_WAIT),
      .clr_i     ((st_q == S_RING) && xfer),
      .miss_i    (miss),
      .gap_done_o(gap_done),
      .last_o    (last_poll)
   );

   mbx_resp_check #(.BASE(MSG_BASE)) i_check (
      .words_i    (rsp_q),
      .sum_ok_o   (sum_ok),
      .ptr_msg_o  (ptr_msg),
      .ptr_fatal_o(ptr_fatal),
      .ptr_addr_o (ptr_addr)
   );

   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      case (st_q)
         S_WRITE: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = ADDR_W'(MSG_BASE + 4 * int'(idx_q));
            bus_wdata = cmd_word(int'(cmd_q), int'(idx_q));
         end
         S_RING: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = ADDR_W'(DBELL_ADDR);
            bus_wdata = 32'd1;
         end
         S_POLL: begin
            bus_req  = 1'b1;
            bus_addr = ADDR_W'(HOSTMB_ADDR);
         end
         S_READ: begin
            bus_req  = 1'b1;
            bus_addr = ADDR_W'(MSG_BASE + 4 * int'(idx_q));
         end
         S_CLEAR: begin
            bus_req  = 1'b1;
            bus_we   = 1'b1;
            bus_addr = ADDR_W'(HOSTMB_ADDR);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         idx_q    <= '0;
         cmd_q    <= '0;
         rsp_q    <= '0;
         code_q   <= '0;
         status_q <= '0;
         tmo_q    <= 1'b0;
      end else begin
         case (st_q)
            S_IDLE: if (start) begin
               cmd_q  <= cmd_idx;
               idx_q  <= '0;
               rsp_q  <= '0;
               code_q <= '0;
               tmo_q  <= 1'b0;
               if (int'(cmd_idx) >= N_CMDS) begin
                  status_q <= ST_BADCMD;
                  st_q     <= S_DONE;
               end else begin
                  st_q <= S_WRITE;
               end
            end
            S_WRITE: if (xfer) begin
               if (int'(idx_q) == FRAME_WORDS - 1) st_q <= S_RING;
               else                                idx_q <= idx_q + 1'b1;
            end
            S_RING: if (xfer) st_q <= S_WAIT;
            S_WAIT: if (gap_done) st_q <= S_POLL;
            S_POLL: if (xfer) begin
               if (bus_rdata != '0) begin
                  code_q <= bus_rdata;
                  idx_q  <= '0;
                  st_q   <= S_READ;
               end else if (last_poll) begin
                  tmo_q <= 1'b1;
                  st_q  <= S_CLEAR;
               end else begin
                  st_q <= S_WAIT;
               end
            end
            S_READ: if (xfer) begin
               rsp_q[idx_q] <= bus_rdata;
               if (int'(idx_q) == FRAME_WORDS - 1) st_q <= S_CLEAR;
               else                                idx_q <= idx_q + 1'b1;
            end
            S_CLEAR: if (xfer) begin
               status_q <= tmo_q ? ST_TIMEOUT : (sum_ok ? code_q : ST_BADSUM);
               st_q     <= S_DONE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != S_IDLE);
   assign done   = (st_q == S_DONE);
   assign status = status_q;

   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);

   p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_clear_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) && (status != ST_BADCMD) |->
         $past(bus_req && bus_ack && bus_we && bus_addr == ADDR_W'(HOSTMB_ADDR) && bus_wdata == '0));

   p_badcmd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) && (status == ST_BADCMD) |-> !$past(bus_req));

endmodule

// File: tb/test_mbx_xact_engine.sv
module test_mbx_xact_engine;
   localparam int MAXP = 8;

   typedef struct {
      logic        we;
      logic [11:0] addr;
      logic [31:0] data;
   } op_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cmd_idx = '0;
   logic [15:0] poll_gap = '0;
   logic        busy, done, ptr_msg, ptr_fatal, bus_req, bus_we;
   logic [31:0] status, bus_wdata;
   logic [28:0] ptr_addr;
   logic [11:0] bus_addr;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   int          n_checks = 0;
   int          n_fail   = 0;
   op_t         exp_q[$];
   int          idle_run = 0;

   int          cfg_zero = 0;
   logic [31:0] cfg_code = 32'd1;
   logic [31:0] cfg_w[5];
   int          polls_seen = 0;

   always #5 clk = ~clk;

   mbx_xact_engine #(.MAX_POLLS(MAXP)) i_mbx_xact_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
      .poll_gap(poll_gap), .busy(busy), .done(done), .status(status),
      .ptr_msg(ptr_msg), .ptr_fatal(ptr_fatal), .ptr_addr(ptr_addr),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

   // Behavioural co-processor: acknowledges one cycle after a request.
   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
      end else if (bus_req && !bus_ack) begin
         bus_ack <= 1'b1;
         if (!bus_we) begin
            if (bus_addr == 12'h014) begin
               bus_rdata <= (polls_seen < cfg_zero) ? 32'd0 : cfg_code;
               polls_seen = polls_seen + 1;
            end else begin
               bus_rdata <= cfg_w[(int'(bus_addr) - 'h100) / 4];
            end
         end
      end else begin
         bus_ack <= 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops expected transfers and checks poll spacing.
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_req && bus_ack) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9/R10 unexpected transfer", {20'd0, bus_addr}, 32'hFFFF_FFFF);
            end else begin
               op_t e;
               e = exp_q.pop_front();
               check(bus_we == e.we && bus_addr == e.addr && (!e.we || bus_wdata == e.data),
                     "R1/R2/R5/R6 transfer", {bus_we, 7'd0, bus_addr, 12'd0} ^ (e.we ? bus_wdata : 32'd0),
                     {e.we, 7'd0, e.addr, 12'd0} ^ (e.we ? e.data : 32'd0));
               if (!bus_we && bus_addr == 12'h014)
                  check(idle_run == int'(poll_gap) + 1, "R3 poll spacing", idle_run, int'(poll_gap) + 1);
            end
            idle_run = 0;
         end else if (!bus_req) begin
            idle_run = idle_run + 1;
         end
      end
   end

   function automatic logic [31:0] fw(input int sel, input int f);
      case (f)
         0: return 32'd1;
         1: return (sel == 0) ? 32'd1 : 32'd2;
         2: return 32'd1;
         3: return (sel == 2) ? 32'd2 : 32'd1;
         default: return 32'(4 + sel);
      endcase
   endfunction

   task automatic push(input logic we, input int addr, input logic [31:0] d);
      op_t o;
      o.we = we; o.addr = 12'(addr); o.data = d;
      exp_q.push_back(o);
   endtask

   task automatic run(input int sel, input int zeros, input logic [31:0] code,
                      input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                      input logic [31:0] w3, input bit fix_sum, input int gap,
                      input bit poke_busy, input string tag);
      logic [31:0] sum, exp_st;
      int cyc;
      cfg_w[0] = w0; cfg_w[1] = w1; cfg_w[2] = w2; cfg_w[3] = w3;
      sum = w0 + w1 + w2 + w3;
      cfg_w[4] = fix_sum ? sum : sum ^ 32'h1;
      cfg_zero = zeros; cfg_code = code; polls_seen = 0;
      poll_gap = 16'(gap);
      if (sel < 3) begin
         for (int f = 0; f < 5; f++) push(1'b1, 'h100 + 4 * f, fw(sel, f));
         push(1'b1, 'h10, 32'd1);
         for (int p = 0; p < ((zeros < MAXP) ? zeros + 1 : MAXP); p++) push(1'b0, 'h14, 32'd0);
         if (zeros < MAXP)
            for (int f = 0; f < 5; f++) push(1'b0, 'h100 + 4 * f, 32'd0);
         push(1'b1, 'h14, 32'd0);
         exp_st = (zeros >= MAXP) ? 32'h8000_0010 : (fix_sum ? code : 32'h8000_0004);
      end else begin
         exp_st = 32'h8000_0002;
      end
      start = 1'b1; cmd_idx = 2'(sel);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         check(busy == 1'b1, {tag, " R10 busy"}, busy, 1);
         if (poke_busy && cyc == 3) begin start = 1'b1; cmd_idx = 2'd3; end
         else start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      if (sel >= 3) check(cyc == 0, {tag, " R9 done next cycle"}, cyc, 0);
      check(done == 1'b1, {tag, " R5 done"}, done, 1);
      check(status == exp_st, {tag, " R4/R6/R7/R9 status"}, status, exp_st);
      check(exp_q.size() == 0, {tag, " R5 transfers left"}, exp_q.size(), 0);
      if (sel < 3 && zeros < MAXP && fix_sum) begin
         logic [3:0] k;
         logic [28:0] ea;
         k = w3[31:28];
         ea = (k == 4'd1) ? ({1'b0, w3[27:0]} + 29'h100) : {1'b0, w3[27:0]};
         check(ptr_msg == (k == 4'd1) && ptr_fatal == (k > 4'd1),
               {tag, " R8 pointer kind"}, {ptr_msg, ptr_fatal}, {k == 4'd1, k > 4'd1});
         if (k <= 4'd1) check(ptr_addr == ea, {tag, " R8 pointer address"}, 32'(ptr_addr), 32'(ea));
      end
      @(negedge clk);
      check(!done && !busy, {tag, " R5/R10 single done"}, {done, busy}, 0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !bus_req && status == 0, "R10 reset state", {busy, done, bus_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R6 R8: info, immediate reply, message-RAM pointer
      run(0, 0, 32'd1, 32'd2, 32'd1, 32'd1, 32'h1000_0020, 1'b1, 0, 1'b0, "info");
      // R3 R8: refresh with spaced polls, data-memory pointer
      run(1, 3, 32'd1, 32'd2, 32'd2, 32'd1, 32'h0000_0ABC, 1'b1, 2, 1'b0, "refresh");
      // R4: reply on the last permitted poll, wrapping checksum
      run(2, MAXP - 1, 32'd1, 32'd2, 32'hFFFF_FFF0, 32'd1, 32'h1000_0040, 1'b1, 0, 1'b0, "lastpoll");
      // R4: timeout
      run(0, MAXP, 32'd1, 32'd2, 32'd1, 32'd1, 32'h1000_0000, 1'b1, 1, 1'b0, "timeout");
      // R7: bad checksum
      run(1, 1, 32'd1, 32'd2, 32'd2, 32'd1, 32'h1000_0004, 1'b0, 0, 1'b0, "badsum");
      // R6: error code passes through
      run(2, 0, 32'h8000_0008, 32'd2, 32'd2, 32'd1, 32'h0000_0010, 1'b1, 0, 1'b0, "errcode");
      // R8: fatal pointer type
      run(0, 0, 32'd1, 32'd2, 32'd1, 32'd1, 32'h3000_0008, 1'b1, 0, 1'b0, "fatal");
      // R9: invalid index
      run(3, 0, 32'd1, 32'd0, 32'd0, 32'd0, 32'd0, 1'b1, 0, 1'b0, "badidx");
      // R10: start during busy is ignored
      run(1, 2, 32'd1, 32'd2, 32'd2, 32'd1, 32'h1000_0100, 1'b1, 3, 1'b1, "pokebusy");
      // R10: start in the done cycle is ignored
      cfg_zero = 0; polls_seen = 0;
      fork
         run(0, 0, 32'd1, 32'd2, 32'd1, 32'd1, 32'h1000_0020, 1'b1, 0, 1'b0, "donestart");
         begin
            while (!done) @(negedge clk);
            start = 1'b1; cmd_idx = 2'd0;
            @(negedge clk);
            start = 1'b0;
         end
      join
      repeat (6) @(negedge clk);
      check(!busy && exp_q.size() == 0, "R10 start at done ignored", busy, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule